// File: doc/BRIEF.md
# Acquisition Sample Ring Producer with Flagged Interrupt

This block is the write side of a ring of converted samples kept in a dual-port memory. Each 16-bit sample that arrives on a valid/data strobe goes into the memory word that the head index points to, and the head index then moves on by one. The host reads samples from its own side of the memory. When it has consumed some, it writes its new position into the tail register. The block derives the number of unread samples from the two indices at all times. It does not hold a separate count that could drift away from them.

The ring depth is a parameter with a default of 2003 words. This is not a power of two, so an index wraps by being compared with the last slot and reset to zero. A generate branch uses plain binary rollover when the depth is a power of two. The host programs an occupancy threshold, usually half the depth. Reaching that threshold sets a sticky flag. An eight-bit flag register also records dropped samples and events from neighbouring logic. An enable mask selects which flags drive the single interrupt line.

Host access is a plain register port: a write strobe with an address, and read data that follows the address combinationally.

Top module: `adc_ring_irq`

## Requirements
- R1: A sample presented with `smp_valid` while the ring is not full produces a memory write in the same cycle. The address is the current head index and the data is `smp_data`. The head index then advances by one. The head index reads at register address 0.
- R2: The head index counts 0 to DEPTH-1 and then returns to 0. With the default depth of 2003 it never holds a value of 2003 or more.
- R3: The level register, at address 2, reads head minus tail when head is greater than or equal to tail. Otherwise it reads head plus DEPTH minus tail.
- R4: Flag bit 0, threshold reached, becomes set in the cycle after the level is at or above a non-zero threshold. The threshold is read and written at address 3. A threshold of 0 never sets the flag.
- R5: A sample that arrives while the level is DEPTH-1 is not written to memory and does not move the head. It sets flag bit 1, sample dropped.
- R6: A write to the tail register, at address 1, takes effect only if the value is below DEPTH. Any larger value leaves the tail unchanged.
- R7: A pulse on bit k of `evt_in` sets flag bit k. The bits are: 2 input hardware fault, 3 output buffer empty, 4 output software fault, 5 output hardware fault, 6 counter finished, 7 command finished.
- R8: The flag register sits at address 4. Its bits stay set until the host writes 1 to them there. Writing 0 leaves a bit unchanged. A set and a clear that land on the same bit in the same cycle leave the bit set.
- R9: `irq` is high exactly when some flag bit is set whose enable bit is also set. The enable mask is at address 5. With the mask at zero, `irq` stays low whatever the flags hold.
- R10: After reset, the head, tail, threshold, flags and mask are all zero, and `irq` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A new converted sample is present |
| smp_data | input | 16 | Sample value |
| evt_in | input | 8 | One-cycle event pulses that set flag bits |
| mem_we | output | 1 | Write enable to the ring memory |
| mem_addr | output | 11 | Ring memory word address (head index) |
| mem_wdata | output | 16 | Data written to the ring memory |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 16 | Host register write data |
| reg_rdata | output | 16 | Host register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that `smp_valid` lasts one cycle per sample. They also assume that the host changes the tail only to positions it has already drained, so the tail never passes the head. The stimulus follows both rules: each sample is a single-cycle strobe with idle cycles around it, and every tail value written is either a position up to the current head or a value above the depth that must be ignored. The scoreboard predicts from its own head, tail and level model which samples are accepted and which are dropped. Any memory write that it did not expect is reported.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

   // host register addresses
   localparam logic [2:0] REG_HEAD   = 3'd0;
   localparam logic [2:0] REG_TAIL   = 3'd1;
   localparam logic [2:0] REG_LEVEL  = 3'd2;
   localparam logic [2:0] REG_THRESH = 3'd3;
   localparam logic [2:0] REG_FLAGS  = 3'd4;
   localparam logic [2:0] REG_MASK   = 3'd5;

   // flag bit positions (consumers decode these)
   localparam int FB_THRESH  = 0;
   localparam int FB_DROP    = 1;
   localparam int FB_IN_HW   = 2;
   localparam int FB_OUT_EMP = 3;
   localparam int FB_OUT_SW  = 4;
   localparam int FB_OUT_HW  = 5;
   localparam int FB_CNT_END = 6;
   localparam int FB_CMD_END = 7;

endpackage

// File: rtl/adcr_index.sv
module adcr_index #(
   parameter int DEPTH = 2003,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          tail_we,
   input  logic [AW-1:0] tail_wdata,
   output logic [AW-1:0] head,
   output logic [AW-1:0] tail
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam bit IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [AW-1:0] head_q, tail_q, head_nx;

   generate
      if (IS_POW2) begin : g_roll
         assign head_nx = head_q + 1'b1;
      end else begin : g_cmp
         assign head_nx = (head_q == LAST) ? '0 : head_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         if (adv)     head_q <= head_nx;
         if (tail_we) tail_q <= tail_wdata;
      end
   end

   assign head = head_q;
   assign tail = tail_q;
endmodule

// File: rtl/adcr_level.sv
module adcr_level #(
   parameter int DEPTH = 2003,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic [AW-1:0] head,
   input  logic [AW-1:0] tail,
   input  logic [AW-1:0] thresh,
   output logic [AW-1:0] level,
   output logic          full,
   output logic          at_thresh
);
   localparam logic [AW:0]   DEPTH_W = (AW+1)'(DEPTH);
   localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

   logic [AW:0] diff;

   always_comb begin
      if (head >= tail) diff = {1'b0, head} - {1'b0, tail};
      else              diff = {1'b0, head} + DEPTH_W - {1'b0, tail};
   end

   assign level     = diff[AW-1:0];
   assign full      = (level == LAST);
   assign at_thresh = (thresh != '0) && (level >= thresh);
endmodule

// File: rtl/adcr_flags.sv
module adcr_flags #(
   parameter int FW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [FW-1:0] set_vec,
   input  logic [FW-1:0] clr_vec,
   input  logic          mask_we,
   input  logic [FW-1:0] mask_wdata,
   output logic [FW-1:0] flags,
   output logic [FW-1:0] mask,
   output logic          irq
);
   logic [FW-1:0] flags_q, mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         mask_q  <= '0;
      end else begin
         flags_q <= (flags_q & ~clr_vec) | set_vec;
         if (mask_we) mask_q <= mask_wdata;
      end
   end

   assign flags = flags_q;
   assign mask  = mask_q;
   assign irq   = |(flags_q & mask_q);
endmodule

// File: rtl/adc_ring_irq.sv
module adc_ring_irq #(
   parameter int DEPTH = 2003,
   parameter int DW    = 16,
   parameter int RW    = 16,
   parameter int FW    = 8,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_valid,
   input  logic [DW-1:0] smp_data,
   input  logic [FW-1:0] evt_in,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [RW-1:0] reg_wdata,
   output logic [RW-1:0] reg_rdata,
   output logic          irq
);
   import adcr_pkg::*;

   localparam logic [RW-1:0] DEPTH_R = RW'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (AW > RW) begin : g_bad_aw
         $error("index width exceeds register width");
      end
      if (FW < 8 || FW > RW) begin : g_bad_fw
         $error("flag width must be 8..RW");
      end
   endgenerate

   logic [AW-1:0] head, tail, level, thresh_q;
   logic          full, at_thresh, accept, drop, tail_we;
   logic [FW-1:0] set_vec, clr_vec, flags, mask;

   assign accept  = smp_valid && !full;
   assign drop    = smp_valid && full;
   assign tail_we = reg_we && (reg_addr == REG_TAIL) && (reg_wdata < DEPTH_R);

   adcr_index #(.DEPTH(DEPTH), .AW(AW)) u_index (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (accept),
      .tail_we    (tail_we),
      .tail_wdata (reg_wdata[AW-1:0]),
      .head       (head),
      .tail       (tail)
   );

   adcr_level #(.DEPTH(DEPTH), .AW(AW)) u_level (
      .head      (head),
      .tail      (tail),
      .thresh    (thresh_q),
      .level     (level),
      .full      (full),
      .at_thresh (at_thresh)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  thresh_q <= '0;
      else if (reg_we && reg_addr == REG_THRESH)   thresh_q <= reg_wdata[AW-1:0];
   end

   always_comb begin
      set_vec            = evt_in;
      set_vec[FB_THRESH] = evt_in[FB_THRESH] | at_thresh;
      set_vec[FB_DROP]   = evt_in[FB_DROP] | drop;
      clr_vec = (reg_we && reg_addr == REG_FLAGS) ? reg_wdata[FW-1:0] : '0;
   end

   adcr_flags #(.FW(FW)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_vec    (set_vec),
      .clr_vec    (clr_vec),
      .mask_we    (reg_we && reg_addr == REG_MASK),
      .mask_wdata (reg_wdata[FW-1:0]),
      .flags      (flags),
      .mask       (mask),
      .irq        (irq)
   );

   assign mem_we    = accept;
   assign mem_addr  = head;
   assign mem_wdata = smp_data;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         REG_HEAD:   reg_rdata = RW'(head);
         REG_TAIL:   reg_rdata = RW'(tail);
         REG_LEVEL:  reg_rdata = RW'(level);
         REG_THRESH: reg_rdata = RW'(thresh_q);
         REG_FLAGS:  reg_rdata = RW'(flags);
         REG_MASK:   reg_rdata = RW'(mask);
         default:    reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/adc_ring_irq_chk.sv
module adc_ring_irq_chk #(
   parameter int DEPTH = 2003,
   parameter int RW    = 16,
   parameter int FW    = 8,
   parameter int AW    = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_valid,
   input logic          mem_we,
   input logic          reg_we,
   input logic [2:0]    reg_addr,
   input logic [RW-1:0] reg_wdata,
   input logic [AW-1:0] head,
   input logic [AW-1:0] level,
   input logic [FW-1:0] flags,
   input logic [FW-1:0] mask,
   input logic          irq
);
   import adcr_pkg::*;
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   // R1: an accepted sample moves the head by one
   a_r1_head_step: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we && head != LAST |=> head == AW'($past(head) + 1'b1));

   // R2: wrap from the last slot to zero
   a_r2_head_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we && head == LAST |=> head == '0);

   // R2: head stays inside the ring
   a_r2_head_range: assert property (@(posedge clk) disable iff (!rst_n)
      head <= LAST);

   // R3: level never exceeds DEPTH-1
   a_r3_level_range: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LAST);

   // R5: a sample at full level is dropped and flagged
   a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid && level == LAST |=> flags[FB_DROP] && $stable(head));

   // R8: drop flag persists unless the host clears it
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flags[FB_DROP] && !(reg_we && reg_addr == REG_FLAGS && reg_wdata[FB_DROP])
      |=> flags[FB_DROP]);

   // R9: zero mask keeps the interrupt quiet
   a_r9_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      mask == '0 |-> !irq);
endmodule

bind adc_ring_irq adc_ring_irq_chk #(.DEPTH(DEPTH), .RW(RW), .FW(FW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_valid (smp_valid),
   .mem_we    (mem_we),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .head      (head),
   .level     (level),
   .flags     (flags),
   .mask      (mask),
   .irq       (irq)
);

// File: tb/adc_ring_irq_bench.sv
`timescale 1ns/1ps
module adc_ring_irq_bench;
   localparam int DEPTH = 2003;
   localparam int AW    = $clog2(DEPTH);

   logic          clk = 0;
   logic          rst_n = 0;
   logic          smp_valid = 0;
   logic [15:0]   smp_data = '0;
   logic [7:0]    evt_in = '0;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [15:0]   mem_wdata;
   logic          reg_we = 0;
   logic [2:0]    reg_addr = '0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic          irq;

   always #5 clk = ~clk;

   adc_ring_irq u_adc_ring_irq (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .evt_in(evt_in), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   int front_m = 0;
   int rear_m = 0;
   logic [31:0] exp_q[$];

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   function automatic int level_m();
      return (front_m - rear_m + DEPTH) % DEPTH;
   endfunction

   // driver: one sample, expected write queued if the model has room
   task automatic push(input logic [15:0] d);
      @(posedge clk); #1;
      smp_valid = 1; smp_data = d;
      if (level_m() < DEPTH - 1) begin
         exp_q.push_back({front_m[15:0], d});
         front_m = (front_m + 1) % DEPTH;
      end
      @(posedge clk); #1;
      smp_valid = 0;
   endtask

   task automatic push_n(input int n);
      for (int i = 0; i < n; i++) push(16'(16'h3000 + i));
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      reg_we = 1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      @(posedge clk); #1;
      reg_addr = a;
      @(negedge clk);
      v = int'(reg_rdata);
   endtask

   task automatic evt(input logic [7:0] e);
      @(posedge clk); #1;
      evt_in = e;
      @(posedge clk); #1;
      evt_in = '0;
   endtask

   // monitor: every memory write must match the next expected item
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R5: unexpected write addr=%0d data=0x%0h expected none", mem_addr, mem_wdata);
         end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check("R1 addr", int'(mem_addr), int'(e[31:16]));
            check("R1 data", int'(mem_wdata), int'(e[15:0]));
         end
      end
   end

   bit done = 0;
   initial begin
      #1_500_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R10 reset state
      rd(3'd0, v); check("R10 head", v, 0);
      rd(3'd1, v); check("R10 tail", v, 0);
      rd(3'd2, v); check("R10 level", v, 0);
      rd(3'd3, v); check("R10 thresh", v, 0);
      rd(3'd4, v); check("R10 flags", v, 0);
      rd(3'd5, v); check("R10 mask", v, 0);
      check("R10 irq", int'(irq), 0);

      // R1 / R3 small fill
      push_n(5);
      rd(3'd0, v); check("R1 head", v, 5);
      rd(3'd2, v); check("R3 level", v, 5);

      // R4 threshold at half depth
      wr(3'd3, 16'd1001);
      wr(3'd5, 16'h0007);
      push_n(995);
      rd(3'd4, v); check("R4 below thresh", v, 0);
      check("R9 irq low", int'(irq), 0);
      push(16'hBEEF);
      rd(3'd4, v); check("R4 thresh flag", v, 1);
      check("R9 irq high", int'(irq), 1);

      // drain and clear
      wr(3'd1, 16'd1001); rear_m = 1001;
      rd(3'd2, v); check("R3 drained", v, 0);
      wr(3'd4, 16'h0001);
      rd(3'd4, v); check("R8 w1c", v, 0);
      check("R9 irq cleared", int'(irq), 0);

      // R2 wrap while filling to capacity
      push_n(2002);
      rd(3'd0, v); check("R2 head wrapped", v, 1000);
      rd(3'd2, v); check("R3 full level", v, 2002);
      push(16'hDEAD);
      rd(3'd0, v); check("R5 head held", v, 1000);
      rd(3'd4, v); check("R5 drop flag", v, 3);

      // R8 clear only bit 1 (bit 0 stays, level above threshold)
      wr(3'd4, 16'h0002);
      rd(3'd4, v); check("R8 partial clear", v, 1);

      // R6 out-of-range tail writes ignored
      wr(3'd1, 16'd2003);
      rd(3'd1, v); check("R6 tail 2003", v, 1001);
      wr(3'd1, 16'hFFFF);
      rd(3'd1, v); check("R6 tail ffff", v, 1001);

      // R3 both branches
      wr(3'd1, 16'd500); rear_m = 500;
      rd(3'd2, v); check("R3 head>=tail", v, 500);
      wr(3'd1, 16'd1500); rear_m = 1500;
      rd(3'd2, v); check("R3 head<tail", v, 1503);

      // R7 event inputs
      evt(8'h04);
      evt(8'h80);
      rd(3'd4, v); check("R7 events", v, 16'h85);
      check("R9 irq masked in", int'(irq), 1);
      wr(3'd5, 16'h0000);
      check("R9 mask zero", int'(irq), 0);

      // R4 threshold zero disables
      wr(3'd3, 16'd0);
      wr(3'd4, 16'h00FF);
      rd(3'd4, v); check("R4 thresh zero", v, 0);

      // R8 set beats clear in the same cycle
      @(posedge clk); #1;
      evt_in = 8'h08; reg_we = 1; reg_addr = 3'd4; reg_wdata = 16'h0008;
      @(posedge clk); #1;
      evt_in = '0; reg_we = 0;
      rd(3'd4, v); check("R8 set wins", v, 16'h08);

      // R1 nothing left pending
      check("R1 queue empty", exp_q.size(), 0);

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule